// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This block walks a linked list of transmit descriptors held in word-addressed memory and plays the buffer each one points to out as a byte packet on a ready/valid stream. A descriptor is three 32-bit words: the buffer byte address, a size word carrying an empty flag and a byte length, and the address of the following descriptor. After the last byte of a packet has been accepted, the engine writes the size word back with the empty flag set, bumps a sent-packet counter and moves to the next descriptor. It stops when it meets a descriptor that is already marked empty. That condition is reported as an underrun, and the enable bit drops at the same time.

Software programs the descriptor pointer and sets the enable bit through a small word register port. It then reads status and acknowledges events by writing ones. The status flags of a receive companion come in on a 4-bit input, so that a single masked interrupt register and a single interrupt line cover both directions. MAC framing, CRC and the inter-frame gap belong to the stage downstream of the byte stream.

Top module: `txchain_dma`

## Requirements
- R1: A descriptor is read as three little-endian words: buffer address at pointer+0, size word at pointer+4, next pointer at pointer+8. In the size word, bit 31 is the empty flag and bits [10:0] are the length in bytes; other bits do not affect the length. Bits [1:0] of the next pointer are ignored.
- R2: Register word 0 is control, with bit 0 as the enable bit. Writing it with bit 0 set while the engine is idle sets enable and starts the walk at the current pointer. Writes to control (word 0) and to the pointer (word 1) while the engine is busy have no effect.
- R3: A write to the descriptor pointer register (word 1) stores the value with bits [1:0] forced to zero.
- R4: Buffer bytes are sent in ascending address order. The byte at address A is taken from bits [8*(A mod 4)+7 : 8*(A mod 4)] of the word at A with bits [1:0] cleared. The last flag is set only on the final byte. A length of 0 sends no byte. While ready is low, the data and the last flag hold steady.
- R5: After the final byte is accepted, the size word is written back at pointer+4 with bit 31 set and all other bits unchanged. Then the count in status bits [23:16] increments, status bit 0 sets, and the pointer takes the next address.
- R6: When a size word with bit 31 set is read, status bit 1 (underrun) sets and enable clears. No byte is sent, and the pointer and the count keep their values.
- R7: Register word 2 is status. Writing it with bit 1 set clears underrun. Writing it with bit 0 set decrements the count, and status bit 0 clears only when the count becomes zero. The count wraps modulo 256 in both directions.
- R8: If a packet completes in the same cycle as a status write with bit 0 set, the count keeps its value and status bit 0 stays set.
- R9: Register word 4 reads as mask (word 3, 8 bits) AND {receive status[3:0], transmit status[3:0]}. Writes to word 4 have no effect. The interrupt line is high exactly when that value is nonzero.
- R10: The memory master keeps at most one request outstanding and holds its address, direction and data until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| rxStatusIn | input | 4 | Receive-side status flags |
| irqOut | output | 1 | Interrupt request |
| memReqValid | output | 1 | Memory request pending |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 32 | Byte address of the word |
| memReqWData | output | 32 | Write data |
| memRespValid | input | 1 | Response for the pending request |
| memRespRData | input | 32 | Read data |
| txData | output | 8 | Stream byte |
| txValid | output | 1 | Stream byte valid |
| txLast | output | 1 | Final byte of packet |
| txReady | input | 1 | Stream sink ready |

## Verification
A packet completion and a software acknowledge of status bit 0 can land in the same cycle, and the counter then has to step up and down at once. The bench stalls the response to the descriptor write-back until the write request is visible. It then releases that response in the same cycle as a status write of bit 0. The count must read back unchanged, with bit 0 still set. An underrun and an underrun acknowledge can also coincide, and setting wins in that case.

// File: rtl/txchain_pkg.sv
`timescale 1ns/1ps
package txchain_pkg;
  localparam int PTR_W  = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_PTR  = 3'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd2;
  localparam logic [REG_AW-1:0] RA_MASK = 3'd3;
  localparam logic [REG_AW-1:0] RA_IRQ  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_BUF, ST_RD_SIZE, ST_RD_NEXT, ST_FETCH, ST_SEND, ST_WB
  } walk_state_e;

  typedef struct packed {
    logic             pktDone;
    logic             underrun;
    logic [PTR_W-1:0] nextPtr;
  } walk_strobe_t;
endpackage

// File: rtl/txchain_regs.sv
`timescale 1ns/1ps
module txchain_regs
  import txchain_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int STAT_W  = 4,
  parameter int CNT_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [STAT_W-1:0] rxStatusIn,
  output logic              irqOut,
  input  logic              busy,
  input  walk_strobe_t      walkStb,
  output logic              startPulse,
  output logic [PTR_W-1:0]  curPtr
);
  localparam int IRQ_W = 2 * STAT_W;

  logic             enBit, sentFlag, undFlag;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [IRQ_W-1:0] mask, irqVec;
  logic [STAT_W-1:0] txStat;
  logic wrCtrl, wrPtr, wrStat, wrMask, ackPkt, ackUnd;

  assign wrCtrl     = regWrEn && (regAddr == RA_CTRL) && !busy;
  assign wrPtr      = regWrEn && (regAddr == RA_PTR) && !busy;
  assign wrStat     = regWrEn && (regAddr == RA_STAT);
  assign wrMask     = regWrEn && (regAddr == RA_MASK);
  assign ackPkt     = wrStat && regWrData[0];
  assign ackUnd     = wrStat && regWrData[1];
  assign startPulse = wrCtrl && regWrData[0];

  assign cntNext = cnt + CNT_W'(walkStb.pktDone) - CNT_W'(ackPkt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      curPtr   <= '0;
      cnt      <= '0;
      sentFlag <= 1'b0;
      undFlag  <= 1'b0;
      mask     <= '0;
    end else begin
      if (walkStb.underrun)  enBit <= 1'b0;
      else if (wrCtrl)       enBit <= regWrData[0];

      if (walkStb.pktDone)   curPtr <= walkStb.nextPtr;
      else if (wrPtr)        curPtr <= {regWrData[PTR_W-1:2], 2'b00};

      cnt <= cntNext;
      if (walkStb.pktDone)                    sentFlag <= 1'b1;
      else if (ackPkt && (cntNext == '0))     sentFlag <= 1'b0;

      if (walkStb.underrun)  undFlag <= 1'b1;
      else if (ackUnd)       undFlag <= 1'b0;

      if (wrMask)            mask <= regWrData[IRQ_W-1:0];
    end
  end

  always_comb begin
    txStat    = '0;
    txStat[0] = sentFlag;
    txStat[1] = undFlag;
  end

  assign irqVec = mask & {rxStatusIn, txStat};
  assign irqOut = |irqVec;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      RA_CTRL: regRdData[0] = enBit;
      RA_PTR:  regRdData = curPtr;
      RA_STAT: begin
        regRdData[CNT_LSB +: CNT_W] = cnt;
        regRdData[STAT_W-1:0]       = txStat;
      end
      RA_MASK: regRdData[IRQ_W-1:0] = mask;
      RA_IRQ:  regRdData[IRQ_W-1:0] = irqVec;
      default: regRdData = '0;
    endcase
  end

  a_r5_done_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    walkStb.pktDone |=> sentFlag);
  a_r6_underrun_drops_en: assert property (@(posedge clk) disable iff (!rstN)
    walkStb.underrun |=> (!enBit && undFlag));
  a_r7_ack_decrements: assert property (@(posedge clk) disable iff (!rstN)
    (ackPkt && !walkStb.pktDone) |=> (cnt == ($past(cnt) - CNT_W'(1))));
  a_r8_both_keep_count: assert property (@(posedge clk) disable iff (!rstN)
    (ackPkt && walkStb.pktDone) |=> ((cnt == $past(cnt)) && sentFlag));
  a_r2_ptr_held_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !walkStb.pktDone) |=> $stable(curPtr));
endmodule

// File: rtl/txchain_ctrl.sv
`timescale 1ns/1ps
module txchain_ctrl
  import txchain_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int EMPTY_BIT = 31,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [PTR_W-1:0]  curPtr,
  output logic              busy,
  output walk_strobe_t      walkStb,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [PTR_W-1:0]  memReqAddr,
  output logic [PTR_W-1:0]  memReqWData,
  input  logic              memRespValid,
  input  logic [PTR_W-1:0]  memRespRData,
  output logic [BYTE_W-1:0] txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady
);
  localparam int LANE_W = $clog2(PTR_W / BYTE_W);
  localparam logic [PTR_W-1:0] WORD_B = PTR_W'(PTR_W / BYTE_W);

  walk_state_e state;
  logic [PTR_W-1:0] bufAddr, sizeWord, nextPtr, dataWord;
  logic [LEN_W-1:0] remain;
  logic [LANE_W-1:0] laneSel;
  logic finalByte;

  assign laneSel   = bufAddr[LANE_W-1:0];
  assign finalByte = (remain == LEN_W'(1));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    memReqAddr  = '0;
    memReqWData = '0;
    case (state)
      ST_RD_BUF:  begin memReqValid = 1'b1; memReqAddr = curPtr; end
      ST_RD_SIZE: begin memReqValid = 1'b1; memReqAddr = curPtr + WORD_B; end
      ST_RD_NEXT: begin memReqValid = 1'b1; memReqAddr = curPtr + 2 * WORD_B; end
      ST_FETCH:   begin
        memReqValid = 1'b1;
        memReqAddr  = {bufAddr[PTR_W-1:LANE_W], {LANE_W{1'b0}}};
      end
      ST_WB: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        memReqAddr  = curPtr + WORD_B;
        memReqWData = sizeWord;
        memReqWData[EMPTY_BIT] = 1'b1;
      end
      default: ;
    endcase
  end

  assign txValid = (state == ST_SEND);
  assign txLast  = txValid && finalByte;
  assign txData  = dataWord[laneSel * BYTE_W +: BYTE_W];

  always_comb begin
    walkStb.pktDone  = (state == ST_WB) && memRespValid;
    walkStb.underrun = (state == ST_RD_SIZE) && memRespValid && memRespRData[EMPTY_BIT];
    walkStb.nextPtr  = {nextPtr[PTR_W-1:LANE_W], {LANE_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bufAddr  <= '0;
      sizeWord <= '0;
      nextPtr  <= '0;
      dataWord <= '0;
      remain   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startPulse) state <= ST_RD_BUF;
        ST_RD_BUF: if (memRespValid) begin
          bufAddr <= memRespRData;
          state   <= ST_RD_SIZE;
        end
        ST_RD_SIZE: if (memRespValid) begin
          sizeWord <= memRespRData;
          remain   <= memRespRData[LEN_W-1:0];
          state    <= memRespRData[EMPTY_BIT] ? ST_IDLE : ST_RD_NEXT;
        end
        ST_RD_NEXT: if (memRespValid) begin
          nextPtr <= memRespRData;
          state   <= (remain == '0) ? ST_WB : ST_FETCH;
        end
        ST_FETCH: if (memRespValid) begin
          dataWord <= memRespRData;
          state    <= ST_SEND;
        end
        ST_SEND: if (txReady) begin
          remain  <= remain - LEN_W'(1);
          bufAddr <= bufAddr + PTR_W'(1);
          if (finalByte)    state <= ST_WB;
          else if (&laneSel) state <= ST_FETCH;
        end
        ST_WB: if (memRespValid) state <= ST_RD_BUF;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRespValid) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite) && $stable(memReqWData)));
  a_r4_stream_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));
  a_r6_stop_on_empty: assert property (@(posedge clk) disable iff (!rstN)
    walkStb.underrun |=> (!txValid && !memReqValid));
  a_r5_wb_sets_empty: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memReqWData[EMPTY_BIT]);
endmodule

// File: rtl/txchain_dma.sv
`timescale 1ns/1ps
module txchain_dma
  import txchain_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int CNT_W  = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [STAT_W-1:0] rxStatusIn,
  output logic              irqOut,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [PTR_W-1:0]  memReqAddr,
  output logic [PTR_W-1:0]  memReqWData,
  input  logic              memRespValid,
  input  logic [PTR_W-1:0]  memRespRData,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady
);
  walk_strobe_t     walkStb;
  logic             busy, startPulse;
  logic [PTR_W-1:0] curPtr;

  txchain_regs #(.CNT_W(CNT_W), .STAT_W(STAT_W), .CNT_LSB(16)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxStatusIn(rxStatusIn),
    .irqOut(irqOut), .busy(busy), .walkStb(walkStb),
    .startPulse(startPulse), .curPtr(curPtr)
  );

  txchain_ctrl #(.LEN_W(LEN_W), .EMPTY_BIT(31), .BYTE_W(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .curPtr(curPtr),
    .busy(busy), .walkStb(walkStb),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWData(memReqWData),
    .memRespValid(memRespValid), .memRespRData(memRespRData),
    .txData(txData), .txValid(txValid), .txLast(txLast), .txReady(txReady)
  );
endmodule

// File: tb/txchain_dma_tb.sv
`timescale 1ns/1ps
module txchain_dma_tb;
  import txchain_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0] rxStatusIn = '0;
  logic irqOut, memReqValid, memReqWrite;
  logic [31:0] memReqAddr, memReqWData;
  logic memRespValid = 1'b0;
  logic [31:0] memRespRData = '0;
  logic [7:0] txData;
  logic txValid, txLast;
  logic txReady = 1'b0;

  txchain_dma u_dut (.*);

  always #2.5 clk = ~clk;

  logic [31:0] mem [0:255];
  int nChecks = 0, nFail = 0, protoErr = 0;
  bit done = 0;
  logic stallWr = 1'b0, releaseWr = 1'b0;
  bit pendSeen = 0; logic [31:0] pendAddr;
  int readyMode = 0; bit phase = 0;
  logic [7:0] capData [0:63];
  bit capLast [0:63];
  int capCount = 0;

  // memory model: one response per request, driven at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      memRespValid = 1'b0; pendSeen = 0;
    end else if (memRespValid) begin
      memRespValid = 1'b0; pendSeen = 0;
    end else begin
      if (pendSeen && (!memReqValid || memReqAddr != pendAddr)) protoErr++;
      if (memReqValid) begin
        if (memReqWrite && stallWr && !releaseWr) begin
          pendSeen = 1; pendAddr = memReqAddr;
        end else begin
          if (memReqWrite) mem[memReqAddr[9:2]] = memReqWData;
          else memRespRData = mem[memReqAddr[9:2]];
          memRespValid = 1'b1; pendSeen = 0;
        end
      end else pendSeen = 0;
    end
  end

  // stream sink
  always @(negedge clk) begin
    logic r;
    phase = ~phase;
    r = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? phase : 1'b0;
    if (!rstN) r = 1'b0;
    if (txValid && r && capCount < 64) begin
      capData[capCount] = txData; capLast[capCount] = txLast; capCount++;
    end
    txReady = r;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    int guard = 0;
    do begin regRead(RA_CTRL, d); guard++; end while (d[0] && guard < 5000);
    chk("R2 engine returns idle", {31'b0, d[0]}, 32'd0);
  endtask

  function automatic logic [7:0] byteAt(input int a);
    logic [31:0] w = mem[a[9:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic checkBytes(input string tag, input int first, input int a, input int n);
    for (int k = 0; k < n; k++) begin
      chk({tag, " byte"}, {24'b0, capData[first+k]}, {24'b0, byteAt(a + k)});
      chk({tag, " last"}, {31'b0, capLast[first+k]}, {31'b0, (k == n - 1)});
    end
  endtask

  task automatic setDesc(input int base, input logic [31:0] b, input logic [31:0] s, input logic [31:0] n);
    mem[base >> 2] = b; mem[(base >> 2) + 1] = s; mem[(base >> 2) + 2] = n;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin regRead(3'(i), d); chk("R2 reset register", d, 32'd0); end
    chk("R9 reset irq line", {31'b0, irqOut}, 0);
    chk("R10 reset no request", {31'b0, memReqValid}, 0);
    chk("R4 reset no stream", {31'b0, txValid}, 0);
  endtask

  task automatic t_ptr_align();
    logic [31:0] d;
    regWrite(RA_PTR, 32'h0000_0103); regRead(RA_PTR, d);
    chk("R3 pointer low bits dropped", d, 32'h0000_0100);
  endtask

  task automatic t_single();
    logic [31:0] d; int c0 = capCount;
    setDesc(32'h100, 32'h200, 32'd5, 32'h110);
    setDesc(32'h110, 32'h0, 32'h8000_0000, 32'h0);
    readyMode = 0;
    regWrite(RA_CTRL, 1); waitIdle();
    chk("R4 byte count single", capCount - c0, 5);
    checkBytes("R4 single", c0, 32'h200, 5);
    chk("R1 R5 writeback size word", mem[32'h104 >> 2], 32'h8000_0005);
    regRead(RA_STAT, d); chk("R5 R6 status after one packet", d, 32'h0001_0003);
    regRead(RA_PTR, d);  chk("R5 pointer follows next", d, 32'h110);
    regRead(RA_CTRL, d); chk("R6 enable cleared", d, 0);
    regWrite(RA_STAT, 2); regRead(RA_STAT, d); chk("R7 underrun ack", d, 32'h0001_0001);
    regWrite(RA_STAT, 1); regRead(RA_STAT, d); chk("R7 ack to zero", d, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] d; int c0 = capCount;
    setDesc(32'h120, 32'h213, 32'h0000_1006, 32'h130);
    setDesc(32'h130, 32'h300, 32'h0, 32'h13E);
    setDesc(32'h13C, 32'h240, 32'd4, 32'h150);
    setDesc(32'h150, 32'h0, 32'h8000_0000, 32'h0);
    readyMode = 1;
    regWrite(RA_PTR, 32'h120); regWrite(RA_CTRL, 1); waitIdle();
    chk("R4 byte count chain", capCount - c0, 10);
    checkBytes("R4 unaligned", c0, 32'h213, 6);
    checkBytes("R4 after empty length", c0 + 6, 32'h240, 4);
    chk("R5 writeback keeps other bits", mem[32'h124 >> 2], 32'h8000_1006);
    chk("R5 zero-length consumed", mem[32'h134 >> 2], 32'h8000_0000);
    chk("R1 next low bits ignored", mem[32'h140 >> 2], 32'h8000_0004);
    regRead(RA_PTR, d);  chk("R5 pointer end of chain", d, 32'h150);
    regRead(RA_STAT, d); chk("R5 count three", d, 32'h0003_0003);
    regWrite(RA_STAT, 3); regRead(RA_STAT, d); chk("R7 bit0 kept while nonzero", d, 32'h0002_0001);
    regWrite(RA_STAT, 1); regWrite(RA_STAT, 1);
    regRead(RA_STAT, d); chk("R7 bit0 clears at zero", d, 32'h0);
    regWrite(RA_STAT, 1); regRead(RA_STAT, d); chk("R7 count wraps down", d, 32'h00FF_0000);
  endtask

  task automatic t_wrap_up();
    logic [31:0] d;
    readyMode = 0;
    mem[32'h104 >> 2] = 32'd5;
    regWrite(RA_PTR, 32'h100); regWrite(RA_CTRL, 1); waitIdle();
    regRead(RA_STAT, d); chk("R7 count wraps up", d, 32'h0000_0003);
    regWrite(RA_STAT, 2);
  endtask

  task automatic t_empty_start();
    logic [31:0] d; int c0 = capCount;
    regWrite(RA_PTR, 32'h150); regWrite(RA_CTRL, 1); waitIdle();
    chk("R6 no bytes on empty", capCount - c0, 0);
    regRead(RA_PTR, d);  chk("R6 pointer kept", d, 32'h150);
    regRead(RA_STAT, d); chk("R6 underrun count kept", d, 32'h0000_0003);
    regWrite(RA_STAT, 2);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d; int c0 = capCount;
    mem[32'h104 >> 2] = 32'd5;
    regWrite(RA_PTR, 32'h100);
    readyMode = 2;
    regWrite(RA_CTRL, 1);
    repeat (30) @(negedge clk);
    chk("R4 stream waits for ready", {31'b0, txValid}, 1);
    regWrite(RA_PTR, 32'h1F0); regWrite(RA_CTRL, 0);
    regRead(RA_CTRL, d); chk("R2 control write ignored busy", d, 1);
    regRead(RA_PTR, d);  chk("R2 pointer write ignored busy", d, 32'h100);
    readyMode = 0; waitIdle();
    checkBytes("R4 after stall", c0, 32'h200, 5);
    regRead(RA_PTR, d);  chk("R2 chain not redirected", d, 32'h110);
    regRead(RA_STAT, d); chk("R5 status after stall", d, 32'h0001_0003);
    regWrite(RA_STAT, 2);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    mem[32'h104 >> 2] = 32'd5;
    regWrite(RA_PTR, 32'h100);
    stallWr = 1'b1;
    regWrite(RA_CTRL, 1);
    do @(negedge clk); while (!(memReqValid && memReqWrite));
    releaseWr <= 1'b1;
    @(negedge clk);
    regAddr <= RA_STAT; regWrData <= 32'd1; regWrEn <= 1'b1;
    @(negedge clk);
    regWrEn <= 1'b0; releaseWr <= 1'b0; stallWr <= 1'b0;
    waitIdle();
    regRead(RA_STAT, d); chk("R8 completion and ack same cycle", d, 32'h0001_0003);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    rxStatusIn = 4'b1010;
    regWrite(RA_MASK, 32'h0F); regRead(RA_IRQ, d);
    chk("R9 tx half masked in", d, 32'h03); chk("R9 line high", {31'b0, irqOut}, 1);
    regWrite(RA_MASK, 32'hF0); regRead(RA_IRQ, d); chk("R9 rx half", d, 32'hA0);
    regWrite(RA_MASK, 32'h0C); regRead(RA_IRQ, d); chk("R9 masked to zero", d, 32'h0);
    chk("R9 line low", {31'b0, irqOut}, 0);
    regWrite(RA_IRQ, 32'hFF); regRead(RA_IRQ, d); chk("R9 write to irq ignored", d, 32'h0);
    regRead(RA_MASK, d); chk("R9 mask unchanged by irq write", d, 32'h0C);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {8'(i) ^ 8'h5A, 8'(i) + 8'd1, ~8'(i), 8'(i)};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ptr_align();
    t_single();
    t_chain();
    t_wrap_up();
    t_empty_start();
    t_busy_ignore();
    t_same_cycle();
    t_irq();
    chk("R10 request held until response", protoErr, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule